// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block stops a transmitter that has been active for too long. It takes a qualified transmit-activity level, which squelch logic upstream has already cleaned up. It counts how many clock cycles that level stays high without a break. When the count reaches the activation limit, a latch trips. The tripped latch forces the transmitter off and raises a jabber flag, which the collision signalling path turns into its tone.

Once tripped, the latch stays set until the transmit input has been low for a long, unbroken unjab interval. Any activity during that interval restarts the quiet count from zero. When the latch releases, the activity count also starts fresh. Both durations are parameters counted in clock cycles. The real values sit in the tens of milliseconds for activation and about half a second for unjab. A bench can use much smaller values.

Top module: `jab_watchdog`

## Requirements
- R1: While reset is asserted, and right after it is released, `tx_disable_o` and `jabber_o` are 0 and both counts are cleared. This holds even if reset arrives while the latch is set.
- R2: With the latch clear, suppose `tx_valid_i` is sampled high on ACT_CYCLES consecutive rising edges. Then `tx_disable_o` is 1 right after the last of those edges.
- R3: A run of fewer than ACT_CYCLES high samples leaves the latch clear. A single low sample discards the count, so the next run starts from zero.
- R4: `jabber_o` equals `tx_disable_o` at all times. A value of 1 on both means the transmitter is blocked and the collision indication is requested.
- R5: With the latch set, suppose `tx_valid_i` is sampled low on UNJAB_CYCLES consecutive rising edges. Then both outputs are 0 right after the last of those edges.
- R6: With the latch set, one high sample of `tx_valid_i` restarts the quiet count. The latch then stays set until a further UNJAB_CYCLES consecutive low samples have been seen.
- R7: After a release, a fresh run of ACT_CYCLES consecutive high samples is needed to set the latch again. Activity counted before the trip does not carry over.
- R8: While `tx_valid_i` stays high, the latch never releases, however long the activity lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Qualified transmit activity level |
| tx_disable_o | output | 1 | 1 blocks the transmit output driver |
| jabber_o | output | 1 | 1 requests the collision indication |

## Verification
The assertions take `tx_valid_i` to be synchronous to `clk_i`, settled before each rising edge, and free of glitches. They also assume reset is released away from an edge. The bench meets this by changing the input only on falling edges and by driving reset from the same falling-edge schedule. The random stimulus is a series of high and low runs. Their lengths scatter on both sides of the activation and unjab limits, so near misses, exact hits and restarts all occur.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic {
    JAB_ARMED   = 1'b0,
    JAB_TRIPPED = 1'b1
  } jab_state_e;

  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/jab_run_cnt.sv
// Counts consecutive cycles with en_i && cond_i; expire_o flags the LIMIT-th one.
module jab_run_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cond_i,
  output logic expire_o
);
  localparam int W = jab_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         run;

  assign run      = en_i && cond_i;
  assign expire_o = run && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run || expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/jab_watchdog.sv
module jab_watchdog #(
  parameter int ACT_CYCLES   = 300_000,
  parameter int UNJAB_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_valid_i,
  output logic tx_disable_o,
  output logic jabber_o
);
  import jab_pkg::*;

  jab_state_e state_q;
  logic       tripped;
  logic       act_expire;
  logic       quiet_expire;

  assign tripped = (state_q == JAB_TRIPPED);

  // activity run, only while armed; held cleared while tripped
  jab_run_cnt #(.LIMIT(ACT_CYCLES)) i_act_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (!tripped),
    .cond_i   (tx_valid_i),
    .expire_o (act_expire)
  );

  // quiet run, only while tripped; any activity restarts it
  jab_run_cnt #(.LIMIT(UNJAB_CYCLES)) i_quiet_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tripped),
    .cond_i   (!tx_valid_i),
    .expire_o (quiet_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= JAB_ARMED;
    end else begin
      unique case (state_q)
        JAB_ARMED:   if (act_expire)   state_q <= JAB_TRIPPED;
        JAB_TRIPPED: if (quiet_expire) state_q <= JAB_ARMED;
        default:                       state_q <= JAB_ARMED;
      endcase
    end
  end

  assign tx_disable_o = tripped;
  assign jabber_o     = tripped;
endmodule

// File: rtl/jab_watchdog_chk.sv
module jab_watchdog_chk #(
  parameter int ACT_CYCLES   = 300_000,
  parameter int UNJAB_CYCLES = 5_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_disable_o,
  input logic jabber_o
);
  localparam int HW = jab_pkg::cnt_width(ACT_CYCLES);
  localparam int LW = jab_pkg::cnt_width(UNJAB_CYCLES);
  localparam logic [HW-1:0] HI_LAST = HW'(ACT_CYCLES - 1);
  localparam logic [HW-1:0] HI_MAX  = HW'(ACT_CYCLES);
  localparam logic [LW-1:0] LO_LAST = LW'(UNJAB_CYCLES - 1);
  localparam logic [LW-1:0] LO_MAX  = LW'(UNJAB_CYCLES);

  logic [HW-1:0] hi_run;
  logic [LW-1:0] lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      if (tx_disable_o || !tx_valid_i) hi_run <= '0;
      else if (hi_run != HI_MAX)       hi_run <= hi_run + 1'b1;
      if (!tx_disable_o || tx_valid_i) lo_run <= '0;
      else if (lo_run != LO_MAX)       lo_run <= lo_run + 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_disable_o && !jabber_o)); // R1

  AST_TRIP_ON_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_disable_o && tx_valid_i && hi_run == HI_LAST) |=> tx_disable_o); // R2

  AST_NO_EARLY_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_disable_o && !(tx_valid_i && hi_run == HI_LAST)) |=> !tx_disable_o); // R3

  AST_FLAGS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jabber_o == tx_disable_o); // R4

  AST_RELEASE_ON_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_disable_o && !tx_valid_i && lo_run == LO_LAST) |=> !tx_disable_o); // R5

  AST_HOLD_UNTIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_disable_o && !(!tx_valid_i && lo_run == LO_LAST)) |=> tx_disable_o); // R6

  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_disable_o && tx_valid_i) |=> tx_disable_o); // R8
endmodule

bind jab_watchdog jab_watchdog_chk #(
  .ACT_CYCLES   (ACT_CYCLES),
  .UNJAB_CYCLES (UNJAB_CYCLES)
) i_jab_watchdog_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_valid_i   (tx_valid_i),
  .tx_disable_o (tx_disable_o),
  .jabber_o     (jabber_o)
);

// File: tb/test_jab_watchdog.sv
`timescale 1ns/1ps
module test_jab_watchdog;
  localparam int ACT   = 16;
  localparam int UNJAB = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_valid_i = 1'b0;
  logic tx_disable_o;
  logic jabber_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the requirements
  bit m_jab = 1'b0;
  int m_hi = 0;
  int m_lo = 0;
  string tag = "R1";

  always #2 clk_i = ~clk_i;

  jab_watchdog #(.ACT_CYCLES(ACT), .UNJAB_CYCLES(UNJAB)) i_jab_watchdog (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_valid_i   (tx_valid_i),
    .tx_disable_o (tx_disable_o),
    .jabber_o     (jabber_o)
  );

  function automatic void model_step(input bit v);
    if (!m_jab) begin
      m_lo = 0;
      if (!v) m_hi = 0;
      else if (m_hi == ACT - 1) begin m_jab = 1'b1; m_hi = 0; end
      else m_hi++;
    end else begin
      m_hi = 0;
      if (v) m_lo = 0;
      else if (m_lo == UNJAB - 1) begin m_jab = 1'b0; m_lo = 0; end
      else m_lo++;
    end
  endfunction

  task automatic check(input string t, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", t, act, exp, $time);
    end
  endtask

  task automatic cmp_outputs();
    check(tag, tx_disable_o, m_jab);
    check("R4", jabber_o, tx_disable_o);
  endtask

  task automatic cyc(input bit v);
    tx_valid_i = v;
    @(posedge clk_i);
    model_step(v);
    @(negedge clk_i);
    cmp_outputs();
  endtask

  task automatic run(input bit v, input int n);
    for (int i = 0; i < n; i++) cyc(v);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tx_valid_i = 1'b0;
    m_jab = 1'b0; m_hi = 0; m_lo = 0;
    @(negedge clk_i);
    check("R1", tx_disable_o, 1'b0);
    check("R1", jabber_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1eaf_5eed));
    @(negedge clk_i);
    tag = "R1"; do_reset();
    run(1'b0, 3);

    tag = "R3"; run(1'b1, ACT - 1); run(1'b0, 1);
    check("R3", tx_disable_o, 1'b0);
    run(1'b1, ACT - 2); run(1'b0, 1); run(1'b1, ACT - 2); run(1'b0, 2);
    check("R3", tx_disable_o, 1'b0);

    tag = "R2"; run(1'b1, ACT - 1);
    check("R2", tx_disable_o, 1'b0);
    run(1'b1, 1);
    check("R2", tx_disable_o, 1'b1);

    tag = "R8"; run(1'b1, 3 * UNJAB);
    check("R8", tx_disable_o, 1'b1);

    tag = "R6"; run(1'b0, UNJAB - 1); run(1'b1, 1); run(1'b0, UNJAB - 1);
    check("R6", tx_disable_o, 1'b1);
    tag = "R5"; run(1'b0, 1);
    check("R5", tx_disable_o, 1'b0);

    tag = "R7"; run(1'b1, ACT - 1); run(1'b0, 1);
    check("R7", tx_disable_o, 1'b0);
    run(1'b1, ACT);
    check("R7", tx_disable_o, 1'b1);

    tag = "R1"; run(1'b1, 3); do_reset();
    check("R1", tx_disable_o, 1'b0);
    run(1'b1, ACT - 1);
    check("R1", tx_disable_o, 1'b0);
    run(1'b0, 1);

    tag = "R2/R3/R5/R6/R7";
    for (int b = 0; b < 200; b++) begin
      run(1'b1, 1 + int'($urandom_range(ACT + 6)));
      run(1'b0, 1 + int'($urandom_range(UNJAB + 6)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule